// File: doc/BRIEF.md
# Core Status Register with Flag Protection

This block holds the processor core's eight-bit status word. It keeps three bank-select bits, two power-state flags (time-out and power-down) and three arithmetic flags (zero, digit-carry, carry). The register takes three kinds of update in the same clock: an explicit write from an instruction whose destination is this register, flag results from the ALU with one update enable per flag, and event strobes from reset, the watchdog and the sleep instruction. The block resolves every overlap between these updates with fixed rules.

Software can never write the two power-state flags. When an instruction writes the register and also produces flags, all three arithmetic bits ignore the written data. Each of them then takes its ALU result if its enable is high, and otherwise keeps its old value. A clear of the register therefore sets zero and leaves digit-carry and carry as they were.

Top module: `core_status_reg`

## Requirements
- R1: While reset is low, and after it, the register reads {3'b000, TO=1, PD=1, ARITH_RST} until the first update. The bit order from MSB to LSB is IRP, RP1, RP0, TO, PD, Z, DC, C.
- R2: A write with no flag update enable high loads bits 7:5 and 2:0 from the write data at the next clock.
- R3: Bits 4 (TO) and 3 (PD) keep their value through any write.
- R4: When a write and at least one flag update enable are high in the same cycle, bits 2:0 ignore the write data. Each enabled flag takes its ALU value and each flag that is not enabled keeps its value. Bits 7:5 still take the write data.
- R5: With no write, every flag whose enable is high (enable and value vectors ordered {Z, DC, C}) loads its ALU value, and the other flags keep their value.
- R6: A watchdog-clear strobe sets both TO and PD.
- R7: A sleep strobe sets TO and clears PD.
- R8: A watchdog time-out strobe clears TO and leaves PD unchanged. It takes priority over watchdog-clear and sleep for TO.
- R9: When sleep and watchdog-clear arrive in the same cycle, PD clears and TO sets.
- R10: When no write, no flag enable and no strobe is active, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wr_en | input | 1 | Instruction writes this register |
| wr_data | input | 8 | Data written by the instruction |
| flag_upd_en | input | 3 | Per-flag ALU update enables {Z, DC, C} |
| flag_upd_val | input | 3 | ALU flag results {Z, DC, C} |
| wdt_clear | input | 1 | Watchdog-clear instruction strobe |
| sleep_req | input | 1 | Sleep instruction strobe |
| wdt_timeout | input | 1 | Watchdog time-out strobe |
| status_q | output | 8 | Current register value |

## Verification
The bench builds the block with ARITH_RST set to 3'b101 rather than the all-zero default. The reset value of the arithmetic flags can then be told apart from a register that was simply cleared. A later write with all data bits zero then shows as a real change on bits 2:0. The same setting makes visible any reset path that ignores the parameter.

// File: rtl/cflag_pkg.sv
package cflag_pkg;
  localparam int SR_W    = 8;
  localparam int N_ARITH = 3;
  localparam int N_BANK  = 3;
  // bit positions inside the status word
  localparam int POS_C   = 0;
  localparam int POS_DC  = 1;
  localparam int POS_Z   = 2;
  localparam int POS_PD  = 3;
  localparam int POS_TO  = 4;
  localparam int POS_BNK = 5;

  // next value of one arithmetic flag
  function automatic logic arith_next(input logic hold, input logic wr_en,
                                      input logic wr_bit, input logic flag_instr,
                                      input logic upd_en, input logic upd_val);
    if (upd_en)                 return upd_val;
    if (wr_en && !flag_instr)   return wr_bit;
    return hold;
  endfunction

  // next {to, pd}: time-out dominates TO, sleep dominates PD
  function automatic logic [1:0] pwr_next(input logic to, input logic pd,
                                          input logic clr, input logic slp,
                                          input logic tmo);
    logic nto, npd;
    nto = tmo ? 1'b0 : ((clr || slp) ? 1'b1 : to);
    npd = slp ? 1'b0 : (clr ? 1'b1 : pd);
    return {nto, npd};
  endfunction
endpackage

// File: rtl/cflag_bank_field.sv
module cflag_bank_field #(
  parameter int N_BANK = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [N_BANK-1:0] wr_bits,
  output logic [N_BANK-1:0] bank_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bank_q <= '0;
    else if (wr_en) bank_q <= wr_bits;
  end

  AST_BANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> bank_q == $past(wr_bits)); // R2
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bank_q)); // R10
endmodule

// File: rtl/cflag_arith_field.sv
module cflag_arith_field
  import cflag_pkg::*;
#(
  parameter int                 N_FLAGS = 3,
  parameter logic [N_FLAGS-1:0] RST_VAL = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [N_FLAGS-1:0] wr_bits,
  input  logic [N_FLAGS-1:0] upd_en,
  input  logic [N_FLAGS-1:0] upd_val,
  output logic [N_FLAGS-1:0] flag_q
);
  // the instruction produces flags: written data is discarded for this field
  logic flag_instr;
  logic write_discard;
  assign flag_instr    = |upd_en;
  assign write_discard = wr_en & flag_instr;

  for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
    logic nxt;
    assign nxt = arith_next(flag_q[i], wr_en, wr_bits[i], flag_instr,
                            upd_en[i], upd_val[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= RST_VAL[i];
      else        flag_q[i] <= nxt;
    end

    AST_DISCARD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      write_discard && !upd_en[i] |=> $stable(flag_q[i])); // R4
    AST_UPDATE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en[i] |=> flag_q[i] == $past(upd_val[i])); // R5
    AST_PLAIN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !flag_instr |=> flag_q[i] == $past(wr_bits[i])); // R2
  end
endmodule

// File: rtl/cflag_power_field.sv
module cflag_power_field
  import cflag_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_bits,
  input  logic       wdt_clear,
  input  logic       sleep_req,
  input  logic       wdt_timeout,
  output logic       to_q,
  output logic       pd_q
);
  logic [1:0] nxt;
  logic       any_evt;
  logic       soft_attempt;
  assign nxt          = pwr_next(to_q, pd_q, wdt_clear, sleep_req, wdt_timeout);
  assign any_evt      = wdt_clear | sleep_req | wdt_timeout;
  // a write tries to put a different value into the protected bits
  assign soft_attempt = wr_en & (wr_bits != {to_q, pd_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_q <= 1'b1;
      pd_q <= 1'b1;
    end else begin
      to_q <= nxt[1];
      pd_q <= nxt[0];
    end
  end

  AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    soft_attempt && !any_evt |=> $stable({to_q, pd_q})); // R3
  AST_CLEAR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clear && !wdt_timeout && !sleep_req |=> to_q && pd_q); // R6
  AST_SLEEP_PD: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> !pd_q); // R7
  AST_TIMEOUT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout |=> !to_q); // R8
  AST_TIMEOUT_PD: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout && !sleep_req && !wdt_clear |=> $stable(pd_q)); // R8
  AST_SLEEP_CLEAR_MIX: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req && wdt_clear && !wdt_timeout |=> to_q && !pd_q); // R9
endmodule

// File: rtl/core_status_reg.sv
module core_status_reg
  import cflag_pkg::*;
#(
  parameter logic [N_ARITH-1:0] ARITH_RST = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SR_W-1:0]    wr_data,
  input  logic [N_ARITH-1:0] flag_upd_en,
  input  logic [N_ARITH-1:0] flag_upd_val,
  input  logic               wdt_clear,
  input  logic               sleep_req,
  input  logic               wdt_timeout,
  output logic [SR_W-1:0]    status_q
);
  logic [N_BANK-1:0]  bank_q;
  logic [N_ARITH-1:0] arith_q;
  logic               to_q;
  logic               pd_q;
  logic               quiet;

  cflag_bank_field #(.N_BANK(N_BANK)) i_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_bits (wr_data[SR_W-1:POS_BNK]),
    .bank_q  (bank_q)
  );

  cflag_power_field i_power (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_bits     (wr_data[POS_TO:POS_PD]),
    .wdt_clear   (wdt_clear),
    .sleep_req   (sleep_req),
    .wdt_timeout (wdt_timeout),
    .to_q        (to_q),
    .pd_q        (pd_q)
  );

  cflag_arith_field #(.N_FLAGS(N_ARITH), .RST_VAL(ARITH_RST)) i_arith (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_bits (wr_data[POS_Z:POS_C]),
    .upd_en  (flag_upd_en),
    .upd_val (flag_upd_val),
    .flag_q  (arith_q)
  );

  assign status_q = {bank_q, to_q, pd_q, arith_q};
  assign quiet    = !wr_en && !(|flag_upd_en) && !wdt_clear && !sleep_req
                    && !wdt_timeout;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> $stable(status_q)); // R10
endmodule

// File: tb/test_core_status_reg.sv
module test_core_status_reg;
  localparam logic [2:0] ARST = 3'b101;
  localparam logic [7:0] RST_EXP = {3'b000, 2'b11, ARST};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [2:0] flag_upd_en = '0;
  logic [2:0] flag_upd_val = '0;
  logic       wdt_clear = 1'b0;
  logic       sleep_req = 1'b0;
  logic       wdt_timeout = 1'b0;
  logic [7:0] status_q;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  core_status_reg #(.ARITH_RST(ARST)) i_core_status_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .flag_upd_en(flag_upd_en), .flag_upd_val(flag_upd_val),
    .wdt_clear(wdt_clear), .sleep_req(sleep_req), .wdt_timeout(wdt_timeout),
    .status_q(status_q)
  );

  // {wr_en, wr_data, upd_en{Z,DC,C}, upd_val, clr, slp, tmo, expected, req}
  typedef logic [29:0] vec_t;
  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    {1'b1, 8'hFF, 3'b000, 3'b000, 3'b000, 8'hFF, 4'd2},  // R2 full write
    {1'b1, 8'h00, 3'b000, 3'b000, 3'b000, 8'h18, 4'd3},  // R3 TO/PD survive
    {1'b1, 8'hA2, 3'b000, 3'b000, 3'b000, 8'hBA, 4'd2},  // R2 mixed pattern
    {1'b1, 8'h00, 3'b100, 3'b100, 3'b000, 8'h1E, 4'd4},  // R4 clear-type
    {1'b1, 8'hE0, 3'b001, 3'b001, 3'b000, 8'hFF, 4'd4},  // R4 data discarded
    {1'b0, 8'h00, 3'b011, 3'b000, 3'b000, 8'hFC, 4'd5},  // R5 partial update
    {1'b0, 8'h00, 3'b000, 3'b000, 3'b010, 8'hF4, 4'd7},  // R7 sleep
    {1'b0, 8'h00, 3'b000, 3'b000, 3'b001, 8'hE4, 4'd8},  // R8 time-out
    {1'b0, 8'h00, 3'b000, 3'b000, 3'b000, 8'hE4, 4'd10}, // R10 idle
    {1'b1, 8'h18, 3'b000, 3'b000, 3'b000, 8'h00, 4'd3},  // R3 write 1s ignored
    {1'b0, 8'h00, 3'b000, 3'b000, 3'b100, 8'h18, 4'd6},  // R6 watchdog clear
    {1'b0, 8'h00, 3'b000, 3'b000, 3'b101, 8'h08, 4'd8},  // R8 beats clear
    {1'b0, 8'h00, 3'b000, 3'b000, 3'b110, 8'h10, 4'd9},  // R9 sleep+clear
    {1'b0, 8'h00, 3'b000, 3'b000, 3'b011, 8'h00, 4'd8},  // R8 beats sleep
    {1'b0, 8'h00, 3'b111, 3'b101, 3'b000, 8'h05, 4'd5}   // R5 all flags
  };

  task automatic check(input logic [7:0] exp, input int req, input string what);
    checks++;
    if (status_q !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, status_q, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 1'b0; wr_data = '0; flag_upd_en = '0; flag_upd_val = '0;
    wdt_clear = 1'b0; sleep_req = 1'b0; wdt_timeout = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check(RST_EXP, 1, "value during reset"); // R1
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 check(RST_EXP, 1, "value after release"); // R1

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      {wr_en, wr_data, flag_upd_en, flag_upd_val,
       wdt_clear, sleep_req, wdt_timeout} = VECS[k][29:12];
      @(posedge clk); #1;
      check(VECS[k][11:4], int'(VECS[k][3:0]), $sformatf("vector %0d", k));
    end

    // directed: holding for several idle cycles (R10)
    @(negedge clk) idle_inputs();
    repeat (3) @(posedge clk);
    #1 check(8'h05, 10, "hold over idle cycles");

    // directed: clear-type write with DC and C differing (R4)
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h00; flag_upd_en = 3'b100; flag_upd_val = 3'b100;
    @(posedge clk); #1 check(8'h05, 4, "clear keeps DC/C, sets Z");

    // directed: reset in the middle of a run (R1)
    @(negedge clk) idle_inputs(); wr_en = 1'b1; wr_data = 8'hE7;
    @(posedge clk); #1 check(8'hE7, 2, "write before reset");
    @(negedge clk) rst_n = 1'b0;
    #1 check(RST_EXP, 1, "asynchronous reset");
    @(negedge clk) begin rst_n = 1'b1; idle_inputs(); end
    @(posedge clk); #1 check(RST_EXP, 1, "after second reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule